// File: doc/BRIEF.md
# UART Baud Generator with Fractional Prescaler

This block makes the timing strobes of an asynchronous serial port. The system clock first goes through a prescaler. In integer mode the prescaler divides by 2 or 3. In fractional mode it is an accumulator that adds a programmable step on every clock. Each prescaler pulse steps a 13-bit down-counting timer. The timer reloads after it reaches zero, and the pulse on which it sits at zero becomes the sample tick. The sample tick runs at sixteen times the bit rate.

A 16-slot counter advances on every sample tick. It gives a one-cycle bit-rate strobe once per bit period. It also marks the three middle slots, 7, 8 and 9. On those slots the receive line is captured, and a majority vote is formed from the three samples.

Software programs the reload value through a 16-bit port that is shared by the write and read paths. A write changes the reload value and also restarts the timer from it. If the run bit is clear at the time of the write, that restart is postponed until the first cycle in which the run bit is set.

Top module: `baud_tick_gen`

## Requirements
- R1: `timerRd` always shows the current timer value in bits 12..0, and bits 15..13 read as zero.
- R2: A cycle with `wrEn`=1 stores `wrData[12:0]` as the reload value. Bits 15..13 of `wrData` are ignored.
- R3: When `wrEn`=1 and `runEn`=1, the timer holds `wrData[12:0]` on the next cycle. No sample tick is given in a cycle that loads the timer.
- R4: When `wrEn`=1 and `runEn`=0, the timer keeps its value. In the first later cycle with `runEn`=1, the timer is loaded from the reload value.
- R5: When `fracEn`=0, the prescaler gives one pulse every 2 clocks if `preSel`=0, and one pulse every 3 clocks if `preSel`=1.
- R6: When `fracEn`=1, a 10-bit accumulator adds `fracStep` on every running clock. It gives one pulse on each carry out of bit 9, so the pulse rate is the clock rate × `fracStep` / 1024.
- R7: On each prescaler pulse the timer counts down by one. A pulse that finds the timer at zero raises `sampleTick` and loads the reload value. So the tick period is reload+1 pulses, and a reload value of 0 gives a tick on every pulse.
- R8: While `runEn`=0, the timer, the slot counter and the prescaler state hold their values, and `sampleTick`, `bitStrobe` and `midSlot` stay 0.
- R9: The slot counter counts sample ticks modulo 16, starting from 0 after reset. `bitStrobe` is high for one cycle on each tick taken in slot 15.
- R10: On ticks taken in slots 7, 8 and 9, `midSlot` is high and `rxLine` is captured into `rxSamples[0]`, `[1]` and `[2]` respectively. `rxVote` is the majority of the three bits of `rxSamples`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run bit for the generator |
| preSel | input | 1 | Integer prescaler select: 0 divides by 2, 1 divides by 3 |
| fracEn | input | 1 | Selects the fractional prescaler |
| fracStep | input | 10 | Accumulator step of the fractional prescaler |
| wrEn | input | 1 | Write strobe for the reload register |
| wrData | input | 16 | Write data for the reload register |
| timerRd | output | 16 | Read view of the timer |
| rxLine | input | 1 | Receive line that is sampled |
| sampleTick | output | 1 | Sample tick at 16 times the bit rate |
| bitStrobe | output | 1 | One-cycle strobe once per bit period |
| midSlot | output | 1 | High on ticks in slots 7, 8 and 9 |
| rxSamples | output | 3 | Line samples taken in slots 7, 8 and 9 |
| rxVote | output | 1 | Majority of `rxSamples` |

## Verification
The generator is run through four prescaler patterns: divide-by-2, divide-by-3, a small fractional step and a step close to the maximum. Each pattern is tried with several reload values, including 0, so that the prescaler rate and the timer period can be told apart in the spacing of the ticks.

Reload writes are issued both while running and while stopped, followed by a later start. This separates an immediate reload from a deferred one, and also catches a reload that is lost. Further writes set bits 15..13, which shows whether those bits are dropped. A pseudo-random receive line gives different slot patterns for the vote, so that slot-to-bit misplacement in the samples shows up.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef struct packed {
    logic inPulse;      // prescaler output pulse, already gated by run
    logic loadTimer;    // load timer this cycle
    logic loadFromBus;  // load value comes from the write data
  } bg_strobe_t;
endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic             preSel,
  input  logic             fracEn,
  input  logic [ACC_W-1:0] fracStep,
  input  logic             wrEn,
  output bg_strobe_t       strobes
);
  logic [1:0]       divCnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accSum;
  logic             intHit;
  logic             pending;

  assign accSum = {1'b0, acc} + {1'b0, fracStep};
  assign intHit = (divCnt >= (preSel ? 2'd2 : 2'd1));

  assign strobes.inPulse     = runEn & (fracEn ? accSum[ACC_W] : intHit);
  assign strobes.loadTimer   = runEn & (wrEn | pending);
  assign strobes.loadFromBus = wrEn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt  <= '0;
      acc     <= '0;
      pending <= 1'b0;
    end else begin
      if (runEn) begin
        if (fracEn) acc <= accSum[ACC_W-1:0];
        else        divCnt <= intHit ? 2'd0 : divCnt + 2'd1;
      end
      if (strobes.loadTimer) pending <= 1'b0;
      else if (wrEn)         pending <= 1'b1;
    end
  end

  // R4: a write while stopped leaves a pending reload behind
  p_defer_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !runEn) |=> pending);
  // R4: a pending reload is taken in the first running cycle
  p_defer_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && runEn) |-> strobes.loadTimer);
  // R5: integer mode never gives two pulses back to back
  p_int_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.inPulse && !fracEn && $past(!fracEn) && $past(runEn)) |-> !$past(strobes.inPulse));
endmodule

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
#(
  parameter int TIMER_W = 13,
  parameter int OVS     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bg_strobe_t         strobes,
  input  logic               wrEn,
  input  logic [TIMER_W-1:0] wrVal,
  input  logic               rxLine,
  output logic [TIMER_W-1:0] timer,
  output logic               sampleTick,
  output logic               bitStrobe,
  output logic               midSlot,
  output logic [2:0]         rxSamples
);
  localparam int SLOT_W = $clog2(OVS);
  localparam int MID_LO = OVS / 2 - 1;

  logic [TIMER_W-1:0] reload;
  logic [SLOT_W-1:0]  slot;

  assign sampleTick = strobes.inPulse && (timer == '0) && !strobes.loadTimer;
  assign bitStrobe  = sampleTick && (slot == SLOT_W'(OVS - 1));
  assign midSlot    = sampleTick && (slot >= SLOT_W'(MID_LO)) && (slot <= SLOT_W'(MID_LO + 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload <= '0;
      timer  <= '0;
      slot   <= '0;
    end else begin
      if (wrEn) reload <= wrVal;
      if (strobes.loadTimer)
        timer <= strobes.loadFromBus ? wrVal : reload;
      else if (strobes.inPulse)
        timer <= (timer == '0) ? reload : timer - 1'b1;
      if (sampleTick) slot <= slot + 1'b1;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_samp
    always_ff @(posedge clk) begin
      if (!rst_n)
        rxSamples[i] <= 1'b0;
      else if (sampleTick && (slot == SLOT_W'(MID_LO + i)))
        rxSamples[i] <= rxLine;
    end
  end

  // R3: a running write shows up in the timer on the next cycle
  p_wr_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && strobes.loadTimer) |=> (timer == $past(wrVal)));
  // R7: a tick always restarts the timer from the reload value
  p_tick_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleTick && !wrEn) |=> (timer == $past(reload)));
  // R9: a bit strobe is followed by slot 0
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bitStrobe |=> (slot == '0));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int TIMER_W = 13,
  parameter int BUS_W   = 16,
  parameter int ACC_W   = 10,
  parameter int OVS     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic             preSel,
  input  logic             fracEn,
  input  logic [ACC_W-1:0] fracStep,
  input  logic             wrEn,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] timerRd,
  input  logic             rxLine,
  output logic             sampleTick,
  output logic             bitStrobe,
  output logic             midSlot,
  output logic [2:0]       rxSamples,
  output logic             rxVote
);
  bg_strobe_t         strobes;
  logic [TIMER_W-1:0] timer;
  logic               unusedHi;

  assign unusedHi = ^wrData[BUS_W-1:TIMER_W];

  baud_tick_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .preSel(preSel),
    .fracEn(fracEn), .fracStep(fracStep), .wrEn(wrEn), .strobes(strobes)
  );

  baud_tick_dp #(.TIMER_W(TIMER_W), .OVS(OVS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrEn(wrEn),
    .wrVal(wrData[TIMER_W-1:0]), .rxLine(rxLine), .timer(timer),
    .sampleTick(sampleTick), .bitStrobe(bitStrobe), .midSlot(midSlot),
    .rxSamples(rxSamples)
  );

  assign timerRd = {{(BUS_W-TIMER_W){1'b0}}, timer};
  assign rxVote  = (rxSamples[0] & rxSamples[1]) | (rxSamples[0] & rxSamples[2]) |
                   (rxSamples[1] & rxSamples[2]);

  // R8: stopped generator keeps the timer and gives no strobes
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> $stable(timerRd));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |-> !(sampleTick || bitStrobe || midSlot));
  // R9: the bit strobe only rides on a sample tick
  p_strobe_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bitStrobe |-> sampleTick);
  // R10: mid slots and the bit strobe never coincide
  p_mid_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({midSlot, bitStrobe}));
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic runEn = 1'b0, preSel = 1'b0, fracEn = 1'b0, wrEn = 1'b0, rxLine = 1'b0;
  logic [9:0]  fracStep = '0;
  logic [15:0] wrData = '0;
  logic [15:0] timerRd;
  logic sampleTick, bitStrobe, midSlot, rxVote;
  logic [2:0] rxSamples;

  int checks = 0, fails = 0;
  string phase = "reset";

  // reference state
  int mTimer = 0, mReload = 0, mDiv = 0, mAcc = 0, mSlot = 0;
  bit mPend = 0;
  bit [2:0] mSamp = 0;
  bit [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .preSel(preSel), .fracEn(fracEn),
    .fracStep(fracStep), .wrEn(wrEn), .wrData(wrData), .timerRd(timerRd),
    .rxLine(rxLine), .sampleTick(sampleTick), .bitStrobe(bitStrobe),
    .midSlot(midSlot), .rxSamples(rxSamples), .rxVote(rxVote)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] act=%0h exp=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  // compare outputs against the model, then advance the model across the next edge
  task automatic cyc();
    bit ld, inP, tk;
    int wv;
    #1;
    wv  = int'(wrData) & 32'h1FFF;
    ld  = runEn && (wrEn || mPend);
    inP = runEn && (fracEn ? ((mAcc + int'(fracStep)) >= 1024) : (mDiv >= (preSel ? 2 : 1)));
    tk  = inP && (mTimer == 0) && !ld;
    chk("R1 timerRd", int'(timerRd), mTimer);
    chk("R7 sampleTick", int'(sampleTick), int'(tk));
    chk("R9 bitStrobe", int'(bitStrobe), int'(tk && mSlot == 15));
    chk("R10 midSlot", int'(midSlot), int'(tk && mSlot >= 7 && mSlot <= 9));
    chk("R10 rxSamples", int'(rxSamples), int'(mSamp));
    chk("R10 rxVote", int'(rxVote),
        int'((mSamp[0] & mSamp[1]) | (mSamp[0] & mSamp[2]) | (mSamp[1] & mSamp[2])));
    if (wrEn) mReload = wv;
    if (ld) mTimer = wrEn ? wv : mReload;
    else if (inP) mTimer = (mTimer == 0) ? mReload : mTimer - 1;
    if (ld) mPend = 0; else if (wrEn) mPend = 1;
    if (runEn) begin
      if (fracEn) mAcc = (mAcc + int'(fracStep)) % 1024;
      else mDiv = inP ? 0 : mDiv + 1;
    end
    if (tk && mSlot >= 7 && mSlot <= 9) mSamp[mSlot-7] = rxLine;
    if (tk) mSlot = (mSlot + 1) % 16;
    @(negedge clk);
    lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rxLine = lfsr[0];
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [15:0] d);
    wrData = d; wrEn = 1'b1; cyc(); wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    phase = "reset";
    run(2);
    // R5: integer divide-by-2, small reload
    phase = "R5 div2"; runEn = 1'b1; wr(16'd3); run(200);
    // R2: upper write bits ignored; R3 immediate reload
    phase = "R2 R3 upper bits"; wr(16'hE005); chk("R2 R3 masked", int'(timerRd), 5); run(150);
    // R5: divide-by-3
    phase = "R5 div3"; preSel = 1'b1; run(200);
    // R7: reload 0 gives a tick per pulse
    phase = "R7 reload0"; wr(16'd0); run(200);
    // R4: deferred reload while stopped, R8 hold
    phase = "R4 R8 stopped"; runEn = 1'b0; run(5); wr(16'd9); run(20);
    runEn = 1'b1; cyc(); chk("R4 deferred load", int'(timerRd), 9); run(100);
    // R6: fractional mode, small and large steps
    phase = "R6 frac300"; fracEn = 1'b1; fracStep = 10'd300; wr(16'd1); run(400);
    phase = "R6 frac1023"; fracStep = 10'd1023; wr(16'd0); run(400);
    phase = "R8 frac hold"; runEn = 1'b0; run(30); runEn = 1'b1; run(100);
    phase = "R3 frac write"; wr(16'h1FFF); run(50); wr(16'd2); run(300);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule